// File: doc/BRIEF.md
# Dual Mode-Configurable Timer/Counter

This block holds two 16-bit timer/counter channels. Each channel is split into a low byte and a high byte, and all of them sit on a small byte-wide register bus. A channel advances either on every machine-cycle tick (timer use) or on falling edges of its own count pin (counter use). A run bit enables counting. An optional gate bit also makes counting depend on an external gate pin, which lets software measure how long that pin stays high.

A shared mode register picks one of four layouts for each channel:
- a 13-bit counter with a 5-bit prescale field in the low byte;
- a plain 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a split mode.

In split mode, channel 0 becomes two independent 8-bit counters. Its high byte takes over channel 1's run bit and overflow flag. Every overflow latches a sticky flag, which is visible on the control register and on a dedicated output pin.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register (mode, control, the four count bytes) reads 0 and both overflow outputs are low.
- R2: A channel advances only when its run bit is 1 and either its gate bit is 0 or its gate pin is high. The mode register holds one nibble per channel: channel 0 in bits 3:0 and channel 1 in bits 7:4. Inside a nibble, bit 3 is the gate bit, bit 2 is the count-pin select and bits 1:0 are the mode.
- R3: With the count-pin select at 0, every tick adds one. With it at 1, the count pin is sampled on each tick, and a 1 on one tick followed by a 0 on the next adds one.
- R4: Mode 1 chains the high and low bytes into one 16-bit up-counter. A wrap from 0xFFFF to 0x0000 sets the channel's flag.
- R5: Mode 0 is a 13-bit counter made of the high byte above bits 4:0 of the low byte. Bits 7:5 of the low byte keep their value. A wrap from 0x1FFF to 0 sets the flag.
- R6: In mode 2 only the low byte counts. A count at 0xFF loads the low byte from the high byte, sets the flag and leaves the high byte unchanged.
- R7: Clearing a run bit freezes the count. Setting it resumes counting from the held value, with no clear.
- R8: Channel 1 in mode 3 holds its count.
- R9: When channel 0 is in mode 3:
  - its low byte is an 8-bit counter under channel 0's gate, select, run bit and flag;
  - its high byte counts every tick while the channel 1 run bit is set, and a wrap of that byte sets flag 1;
  - channel 1, if in modes 0 to 2, counts regardless of its run bit (its gate condition still applies), and its wraps set no flag.
- R10: Flags are sticky. A control write with a 0 in a flag position clears that flag. A 1 in that position has no effect. An overflow in the same cycle as a clearing write leaves the flag set.
- R11: A bus write to a count byte in the same cycle as a count gives that byte the written value. Any carry the count produces into the other byte still happens.
- R12: Register map by address:
  - 0: mode register;
  - 1: control register, with bit 0 = run 0, bit 1 = flag 0, bit 2 = run 1, bit 3 = flag 1, and bits 7:4 reading 0;
  - 2 and 3: channel 0 low and high bytes;
  - 4 and 5: channel 1 low and high bytes;
  - 6 and 7: read 0.

  Reads are combinational.
- R13: `ovf_o[i]` always equals flag i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Machine-cycle tick enable |
| cnt_pin_i | input | 2 | External count pin per channel |
| gate_pin_i | input | 2 | External gate pin per channel |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` |
| ovf_o | output | 2 | Overflow flag per channel |

## Verification
Several properties are checked on every cycle:
- a channel with no count and no write keeps both bytes;
- the mode-2 reload copies the old high byte;
- the 16-bit wrap lands on zero;
- a written byte takes the bus value;
- channel 1 in mode 3 stays still;
- a set flag survives unless a clearing write arrives;
- in split mode, channel 1's wraps leave flag 1 clear.

Three behaviours only show up in the bench's scenarios, where a reference model is compared with every read:
- the gate and edge-select qualification;
- the 13-bit carry from bit 4 into the high byte;
- the hand-over of run bit 1 and flag 1 to channel 0's high byte.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_13B   = 2'd0,
    MD_16B   = 2'd1,
    MD_8RL   = 2'd2,
    MD_SPLIT = 2'd3
  } tmr_mode_e;

  localparam int unsigned ADR_MODE     = 0;
  localparam int unsigned ADR_CTRL     = 1;
  localparam int unsigned ADR_CNT_BASE = 2;

  localparam int unsigned NIB_W    = 4;
  localparam int unsigned NIB_GATE = 3;
  localparam int unsigned NIB_CSEL = 2;

  localparam int unsigned CTL_RUN0 = 0;
  localparam int unsigned CTL_FLG0 = 1;
  localparam int unsigned CTL_RUN1 = 2;
  localparam int unsigned CTL_FLG1 = 3;
endpackage

// File: rtl/tmr_edge_sense.sv
module tmr_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (tick_i) begin
      prev_q <= pin_i;
    end
  end

  assign fall_o = tick_i & prev_q & ~pin_i;
endmodule

// File: rtl/tmr_cnt_gate.sv
module tmr_cnt_gate (
  input  logic tick_i,
  input  logic run_i,
  input  logic gate_en_i,
  input  logic gate_pin_i,
  input  logic csel_i,
  input  logic fall_i,
  output logic inc_o
);
  logic enabled;
  logic event_ok;

  always_comb begin
    enabled  = run_i & (~gate_en_i | gate_pin_i);
    event_ok = csel_i ? fall_i : 1'b1;
    inc_o    = tick_i & enabled & event_ok;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned PRE_W     = 5,
  parameter bit          SPLIT_CAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode_i,
  input  logic              inc_i,
  input  logic              hi_inc_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ovf_o,
  output logic              ovf_hi_o
);
  localparam int unsigned W2 = 2 * BYTE_W;

  logic [BYTE_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [W2:0]       wide_sum;
  logic [BYTE_W:0]   hi_sum;
  logic              upd;

  assign wide_sum = {1'b0, hi_q, lo_q} + 1'b1;
  assign hi_sum   = {1'b0, hi_q} + 1'b1;
  assign upd      = inc_i | hi_inc_i | wr_lo_i | wr_hi_i;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    ovf_o    = 1'b0;
    ovf_hi_o = 1'b0;
    unique case (mode_i)
      MD_13B: begin
        if (inc_i) begin
          if (&lo_q[PRE_W-1:0]) begin
            lo_d[PRE_W-1:0] = '0;
            hi_d            = hi_sum[BYTE_W-1:0];
            ovf_o           = hi_sum[BYTE_W];
          end else begin
            lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
          end
        end
      end
      MD_16B: begin
        if (inc_i) begin
          {hi_d, lo_d} = wide_sum[W2-1:0];
          ovf_o        = wide_sum[W2];
        end
      end
      MD_8RL: begin
        if (inc_i) begin
          if (&lo_q) begin
            lo_d  = hi_q;
            ovf_o = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
      end
      MD_SPLIT: begin
        if (SPLIT_CAP) begin
          if (inc_i) begin
            lo_d  = lo_q + 1'b1;
            ovf_o = &lo_q;
          end
          if (hi_inc_i) begin
            hi_d     = hi_sum[BYTE_W-1:0];
            ovf_hi_o = hi_sum[BYTE_W];
          end
        end
      end
      default: ;
    endcase
    if (wr_lo_i) lo_d = wdata_i;
    if (wr_hi_i) hi_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (upd) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_i || hi_inc_i || wr_lo_i || wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_8RL && inc_i && (&lo_q) && !wr_lo_i && !wr_hi_i)
      |=> (lo_q == $past(hi_q) && $stable(hi_q)));

  // R4
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_16B && inc_i && (&{hi_q, lo_q}) && !wr_lo_i && !wr_hi_i)
      |=> (lo_q == '0 && hi_q == '0));

  // R11
  wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> (lo_q == $past(wdata_i)));

  generate
    if (!SPLIT_CAP) begin : g_hold3
      // R8
      mode3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_SPLIT && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));
    end
  endgenerate
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned PRE_W  = 5,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        cnt_pin_i,
  input  logic [1:0]        gate_pin_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic [1:0]        ovf_o
);
  localparam int unsigned NCH    = 2;
  localparam int unsigned MODE_W = NIB_W * NCH;

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [NCH-1:0]    run_q, run_d, flag_q, flag_d;
  logic              mode_wr, ctl_wr, split;
  logic [NCH-1:0]    ovf_main, ovf_hi;
  logic [BYTE_W-1:0] lo_b [NCH];
  logic [BYTE_W-1:0] hi_b [NCH];

  assign mode_wr = bus_we_i && (bus_addr_i == ADDR_W'(ADR_MODE));
  assign ctl_wr  = bus_we_i && (bus_addr_i == ADDR_W'(ADR_CTRL));
  assign split   = (mode_q[1:0] == MD_SPLIT);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [NIB_W-1:0] nib;
      logic             fall, inc, run_eff, hi_inc, wr_lo, wr_hi;

      assign nib   = mode_q[NIB_W*i +: NIB_W];
      assign wr_lo = bus_we_i && (bus_addr_i == ADDR_W'(ADR_CNT_BASE + 2*i));
      assign wr_hi = bus_we_i && (bus_addr_i == ADDR_W'(ADR_CNT_BASE + 2*i + 1));

      if (i == 0) begin : g_c0
        assign run_eff = run_q[0];
        assign hi_inc  = tick_i & run_q[1];
      end else begin : g_c1
        assign run_eff = run_q[1] | split;
        assign hi_inc  = 1'b0;
      end

      tmr_edge_sense u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .pin_i  (cnt_pin_i[i]),
        .fall_o (fall)
      );

      tmr_cnt_gate u_gate (
        .tick_i     (tick_i),
        .run_i      (run_eff),
        .gate_en_i  (nib[NIB_GATE]),
        .gate_pin_i (gate_pin_i[i]),
        .csel_i     (nib[NIB_CSEL]),
        .fall_i     (fall),
        .inc_o      (inc)
      );

      tmr_chan #(
        .BYTE_W    (BYTE_W),
        .PRE_W     (PRE_W),
        .SPLIT_CAP (i == 0)
      ) u_chan (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (tmr_mode_e'(nib[1:0])),
        .inc_i    (inc),
        .hi_inc_i (hi_inc),
        .wr_lo_i  (wr_lo),
        .wr_hi_i  (wr_hi),
        .wdata_i  (bus_wdata_i),
        .lo_o     (lo_b[i]),
        .hi_o     (hi_b[i]),
        .ovf_o    (ovf_main[i]),
        .ovf_hi_o (ovf_hi[i])
      );
    end
  endgenerate

  logic flag1_set;
  assign flag1_set = split ? ovf_hi[0] : (ovf_main[1] | ovf_hi[1]);

  always_comb begin
    mode_d    = mode_wr ? bus_wdata_i[MODE_W-1:0] : mode_q;
    run_d     = run_q;
    if (ctl_wr) begin
      run_d[0] = bus_wdata_i[CTL_RUN0];
      run_d[1] = bus_wdata_i[CTL_RUN1];
    end
    flag_d[0] = ovf_main[0] | (flag_q[0] & ~(ctl_wr & ~bus_wdata_i[CTL_FLG0]));
    flag_d[1] = flag1_set   | (flag_q[1] & ~(ctl_wr & ~bus_wdata_i[CTL_FLG1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (mode_wr) mode_q <= mode_d;
      if (ctl_wr)  run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_W'(ADR_MODE):         bus_rdata_o = BYTE_W'(mode_q);
      ADDR_W'(ADR_CTRL):         bus_rdata_o = BYTE_W'({flag_q[1], run_q[1], flag_q[0], run_q[0]});
      ADDR_W'(ADR_CNT_BASE):     bus_rdata_o = lo_b[0];
      ADDR_W'(ADR_CNT_BASE + 1): bus_rdata_o = hi_b[0];
      ADDR_W'(ADR_CNT_BASE + 2): bus_rdata_o = lo_b[1];
      ADDR_W'(ADR_CNT_BASE + 3): bus_rdata_o = hi_b[1];
      default:                   bus_rdata_o = '0;
    endcase
  end

  assign ovf_o = flag_q;

  // R10
  flag0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !(ctl_wr && !bus_wdata_i[CTL_FLG0])) |=> flag_q[0]);

  // R10
  flag1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[1] && !(ctl_wr && !bus_wdata_i[CTL_FLG1])) |=> flag_q[1]);

  // R9
  split_c1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !flag_q[1] && !ovf_hi[0] && ovf_main[1]) |=> !flag_q[1]);
endmodule

// File: tb/tmr_pair_tb.sv
`timescale 1ns/1ps
module tmr_pair_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic [1:0] cpin, gpin;
  logic       we;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic [1:0] ovf;

  always #2.5 clk = ~clk;

  tmr_pair dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .cnt_pin_i   (cpin),
    .gate_pin_i  (gpin),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .ovf_o       (ovf)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_mode, m_lo [2], m_hi [2];
  logic [1:0] m_run, m_flag, m_prev;
  logic [7:0] n_mode, n_lo [2], n_hi [2];
  logic [1:0] n_run, n_flag, n_prev;
  logic [1:0] cp_g = 2'b00, gp_g = 2'b00;

  // returns {ovf, hi, lo} for modes 0..2
  function automatic logic [16:0] adv(input logic [1:0] md, input logic [7:0] lo,
                                      input logic [7:0] hi, input logic inc);
    logic [12:0] v13;
    logic [16:0] v16;
    if (!inc) return {1'b0, hi, lo};
    case (md)
      2'd0: begin
        v13 = {hi, lo[4:0]} + 13'd1;
        return {({hi, lo[4:0]} == 13'h1FFF), v13[12:5], lo[7:5], v13[4:0]};
      end
      2'd1: begin
        v16 = {1'b0, hi, lo} + 17'd1;
        return v16;
      end
      default: begin
        if (lo == 8'hFF) return {1'b1, hi, hi};
        return {1'b0, hi, lo + 8'd1};
      end
    endcase
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return {4'b0, m_flag[1], m_run[1], m_flag[0], m_run[0]};
      3'd2: return m_lo[0];
      3'd3: return m_hi[0];
      3'd4: return m_lo[1];
      3'd5: return m_hi[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step(input logic t, input logic w, input logic [2:0] a, input logic [7:0] d);
    logic [1:0] fall, en, inc;
    logic spl, oh, o0, o1, f1s;
    logic [16:0] r;
    spl = (m_mode[1:0] == 2'd3);
    for (int c = 0; c < 2; c++) begin
      fall[c]   = t & m_prev[c] & ~cp_g[c];
      n_prev[c] = t ? cp_g[c] : m_prev[c];
    end
    en[0]  = m_run[0] & (~m_mode[3] | gp_g[0]);
    en[1]  = (m_run[1] | spl) & (~m_mode[7] | gp_g[1]);
    inc[0] = t & en[0] & (m_mode[2] ? fall[0] : 1'b1);
    inc[1] = t & en[1] & (m_mode[6] ? fall[1] : 1'b1);
    oh = 1'b0;
    if (spl) begin
      n_lo[0] = m_lo[0] + {7'd0, inc[0]};
      o0 = inc[0] & (m_lo[0] == 8'hFF);
      n_hi[0] = m_hi[0] + {7'd0, (t & m_run[1])};
      oh = t & m_run[1] & (m_hi[0] == 8'hFF);
    end else begin
      r = adv(m_mode[1:0], m_lo[0], m_hi[0], inc[0]);
      {o0, n_hi[0], n_lo[0]} = r;
    end
    if (m_mode[5:4] == 2'd3) begin
      n_lo[1] = m_lo[1]; n_hi[1] = m_hi[1]; o1 = 1'b0;
    end else begin
      r = adv(m_mode[5:4], m_lo[1], m_hi[1], inc[1]);
      {o1, n_hi[1], n_lo[1]} = r;
    end
    f1s = spl ? oh : o1;
    n_mode = m_mode;
    n_run = m_run;
    n_flag[0] = o0 | (m_flag[0] & ~(w && a == 3'd1 && !d[1]));
    n_flag[1] = f1s | (m_flag[1] & ~(w && a == 3'd1 && !d[3]));
    if (w) begin
      case (a)
        3'd0: n_mode = d;
        3'd1: n_run = {d[2], d[0]};
        3'd2: n_lo[0] = d;
        3'd3: n_hi[0] = d;
        3'd4: n_lo[1] = d;
        3'd5: n_hi[1] = d;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input logic t, input logic w, input logic [2:0] a,
                     input logic [7:0] d, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    tick = t; we = w; addr = a; wdata = d; cpin = cp_g; gpin = gp_g;
    #1;
    exp = m_read(a);
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: read addr %0d got %h expected %h", tag, a, rdata, exp);
    end
    n_chk++;
    if (ovf !== m_flag) begin
      n_fail++;
      $display("FAIL %s (R13): ovf_o got %b expected %b", tag, ovf, m_flag);
    end
    model_step(t, w, a, d);
    @(posedge clk);
    #0.5;
    m_mode = n_mode; m_run = n_run; m_flag = n_flag; m_prev = n_prev;
    for (int c = 0; c < 2; c++) begin
      m_lo[c] = n_lo[c];
      m_hi[c] = n_hi[c];
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    cyc(1'b0, 1'b1, a, d, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'(i % 8), 8'h00, tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; tick = 0; we = 0; addr = 0; wdata = 0; cpin = 0; gpin = 0;
    m_mode = 0; m_run = 0; m_flag = 0; m_prev = 0;
    for (int c = 0; c < 2; c++) begin m_lo[c] = 0; m_hi[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R12: reset state across the whole address range
    for (int a = 0; a < 8; a++) cyc(1'b0, 1'b0, 3'(a), 8'h00, "R1 R12");

    // R4: 16-bit wrap on channel 0
    wr(3'd0, 8'h11, "R4"); wr(3'd2, 8'hFD, "R4"); wr(3'd3, 8'hFF, "R4");
    wr(3'd1, 8'h01, "R4"); ticks(6, "R4");

    // R10: 1 in flag position keeps it, 0 clears
    wr(3'd1, 8'h02, "R10"); ticks(2, "R10");
    wr(3'd1, 8'h00, "R10"); ticks(2, "R10");

    // R5: 13-bit layout, upper low-byte bits held
    wr(3'd0, 8'h00, "R5"); wr(3'd2, 8'hFC, "R5"); wr(3'd3, 8'hFF, "R5");
    wr(3'd1, 8'h01, "R5"); ticks(8, "R5");
    wr(3'd2, 8'hBF, "R5"); wr(3'd3, 8'h12, "R5"); ticks(4, "R5");

    // R6: 8-bit reload
    wr(3'd0, 8'h02, "R6"); wr(3'd3, 8'hFC, "R6"); wr(3'd2, 8'hFE, "R6");
    ticks(12, "R6");

    // R7: run off freezes, run on resumes without clearing
    wr(3'd1, 8'h00, "R7"); ticks(5, "R7");
    wr(3'd1, 8'h01, "R7"); ticks(3, "R7");

    // R2: gate bit with gate pin
    wr(3'd0, 8'h09, "R2"); gp_g = 2'b00; ticks(4, "R2");
    gp_g = 2'b01; ticks(4, "R2"); gp_g = 2'b00;

    // R3: count-pin falling edges
    wr(3'd0, 8'h05, "R3"); wr(3'd2, 8'h00, "R3");
    for (int i = 0; i < 10; i++) begin cp_g[0] = ~cp_g[0]; cyc(1'b1, 1'b0, 3'd2, 8'h00, "R3"); end
    cp_g = 2'b00;

    // R8: channel 1 in mode 3 holds
    wr(3'd0, 8'h31, "R8"); wr(3'd4, 8'h55, "R8"); wr(3'd1, 8'h05, "R8");
    ticks(6, "R8");

    // R9: split mode hand-over
    wr(3'd1, 8'h00, "R9");
    wr(3'd0, 8'h13, "R9"); wr(3'd2, 8'hFE, "R9"); wr(3'd3, 8'hFD, "R9");
    wr(3'd4, 8'hFE, "R9"); wr(3'd5, 8'hFF, "R9");
    wr(3'd1, 8'h04, "R9"); ticks(6, "R9");
    wr(3'd1, 8'h05, "R9"); ticks(4, "R9");

    // R11: write beats a same-cycle count
    wr(3'd0, 8'h11, "R11");
    cyc(1'b1, 1'b1, 3'd2, 8'h40, "R11"); ticks(2, "R11");
    cyc(1'b1, 1'b1, 3'd3, 8'h7F, "R11"); ticks(2, "R11");

    // mixed random traffic
    for (int k = 0; k < 5000; k++) begin
      logic t, w; logic [2:0] a; logic [7:0] d;
      t = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) cp_g = 2'($urandom);
      if (($urandom % 16) == 0) gp_g = 2'($urandom);
      w = ($urandom % 6) == 0;
      a = 3'($urandom);
      d = 8'($urandom);
      if (a >= 3'd2 && a <= 3'd5 && ($urandom % 2)) d = d | 8'hF0;
      if (a == 3'd1 && ($urandom % 4) != 0) d = d | 8'h0F;
      cyc(t, w, a, d, "MIX");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule